// File: doc/BRIEF.md
# Audio Soft Mute Ramp Controller

This block fades a stereo stream of signed 24-bit audio samples smoothly to silence when a mute is requested, and fades it back up when the request is withdrawn. A gain value is stepped once per left/right frame strobe. Each sample of that frame is multiplied by the gain, rounded back to 24 bits and saturated. The number of frames a full fade takes depends on a 2-bit operating-rate mode. The fade therefore lasts the same wall-clock time whether the stream runs at single, double or quad sample rate.

An active-low mute-status output drives an external analog mute circuit. It drops only once a fade toward silence has fully reached zero gain. It rises again as soon as the mute request is withdrawn, while the up-fade is still running. The status is also held low during reset, during power-down and while the clock-ratio-error flag is raised. If the mute request reverses in the middle of a fade, the fade turns around from the gain it has reached, with no restart.

Top module: `soft_mute_ramp`

## Requirements
- R1: A full fade in either direction lasts exactly 1152 frame strobes when `rateMode` is 2'b00 (single rate), 2304 when it is 2'b01 (double rate), and 4608 when it is 2'b10 or 2'b11 (quad rate). The gain is counted on a 0..4608 scale and steps by 4, 2 or 1 per strobe respectively.
- R2: While `muteReq` is high, each frame strobe lowers the gain by one step, stopping at zero.
- R3: While `muteReq` is low, each frame strobe raises the gain by one step, stopping at unity.
- R4: For a frame accepted at gain k (0..4608), each output equals sample*k/4608 rounded to the nearest integer and saturated to the signed 24-bit range, within 2 LSB.
- R5: A frame accepted at zero gain gives outputs of exactly 0. A frame accepted at unity gain gives outputs bit-identical to its inputs, including the extremes 8388607 and -8388608.
- R6: `muteStatusN` stays high during a fade toward silence. It goes low at the second clock edge after the strobe of the frame whose step brings the gain to zero, and stays low while `muteReq` remains high.
- R7: `muteStatusN` returns high at the first clock edge after `muteReq` falls, even mid-fade, provided reset, power-down and clock-ratio error are inactive.
- R8: `muteStatusN` is low without waiting for a clock edge while `rstN` is low, `powerDown` is high or `clkRatioErr` is high.
- R9: A change of `muteReq` during a fade reverses its direction from the current gain. After d steps down from unity and d steps back up, the gain is exactly unity again.
- R10: After reset the gain is zero, the outputs are zero and an up-fade starts with the next strobe if `muteReq` is low. If `muteReq` is held high through reset, `muteStatusN` stays low after release. Power-down clears the gain and both outputs at the next clock edge and holds them at zero while it lasts.
- R11: The gain changes only on frame strobes. The outputs load at the clock edge where `frameStb` is high and hold their value on every other edge, whatever the sample inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| powerDown | input | 1 | Power-down: clears gain and outputs, forces status low |
| clkRatioErr | input | 1 | Clock-ratio error flag: forces status low |
| rateMode | input | 2 | 00 single, 01 double, 10/11 quad rate |
| muteReq | input | 1 | Mute request, high to fade to silence |
| frameStb | input | 1 | One-cycle strobe per left/right frame |
| sampleL | input | 24 | Signed left sample, valid with the strobe |
| sampleR | input | 24 | Signed right sample, valid with the strobe |
| outL | output | 24 | Scaled signed left sample |
| outR | output | 24 | Scaled signed right sample |
| muteStatusN | output | 1 | Mute status for external circuit, low when muted |

## Verification
The scaled outputs are due at the clock edge that samples a high `frameStb`. They use the gain held before that frame's step, so the bench raises the strobe at a falling edge and reads both outputs at the next falling edge, against a gain model that advances only after the comparison. The muted status lags the zeroing frame by one further edge, and the release of the status lags the fall of `muteReq` by one edge. The bench checks the status at both falling edges around each transition, so an early or late change is caught. Reset, power-down and clock-ratio error act on the status without a clock, and are checked in the same half-cycle in which they are driven.

// File: rtl/mute_ramp_pkg.sv
package mute_ramp_pkg;

  localparam int DATA_W        = 24;
  localparam int SINGLE_FRAMES = 1152;
  localparam int QUAD_RATIO    = 4;
  localparam int FULL_SCALE    = SINGLE_FRAMES * QUAD_RATIO;
  localparam int GAIN_W        = $clog2(FULL_SCALE + 1);
  localparam int FRAC_W        = 23;

  typedef enum logic [1:0] {
    RATE_SINGLE = 2'b00,
    RATE_DOUBLE = 2'b01,
    RATE_QUAD   = 2'b10,
    RATE_QUAD_B = 2'b11
  } rate_mode_e;

  typedef struct packed {
    logic              load;
    logic              clear;
    logic [GAIN_W-1:0] gain;
  } ctrl_strobe_t;

endpackage

// File: rtl/mute_ramp_ctrl.sv
module mute_ramp_ctrl
  import mute_ramp_pkg::*;
#(
  parameter int FULL = FULL_SCALE
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         powerDown,
  input  logic         clkRatioErr,
  input  logic [1:0]   rateMode,
  input  logic         muteReq,
  input  logic         frameStb,
  output ctrl_strobe_t ctl,
  output logic         muteStatusN
);

  localparam int STEP_SINGLE = QUAD_RATIO;
  localparam int STEP_DOUBLE = QUAD_RATIO / 2;
  localparam int STEP_QUAD   = 1;
  localparam logic [GAIN_W:0] FULL_EXT = (GAIN_W+1)'(FULL);

  logic [GAIN_W-1:0] gain;
  logic [GAIN_W-1:0] gainNext;
  logic [GAIN_W:0]   stepSize;
  logic [GAIN_W:0]   gainUp;
  logic              muted;
  rate_mode_e        modeSel;

  assign modeSel = rate_mode_e'(rateMode);

  always_comb begin
    case (modeSel)
      RATE_SINGLE: stepSize = (GAIN_W+1)'(STEP_SINGLE);
      RATE_DOUBLE: stepSize = (GAIN_W+1)'(STEP_DOUBLE);
      default:     stepSize = (GAIN_W+1)'(STEP_QUAD);
    endcase
  end

  assign gainUp = {1'b0, gain} + stepSize;

  always_comb begin
    gainNext = gain;
    if (powerDown) begin
      gainNext = '0;
    end else if (frameStb) begin
      if (muteReq) begin
        if ({1'b0, gain} > stepSize) gainNext = gain - stepSize[GAIN_W-1:0];
        else                         gainNext = '0;
      end else begin
        if (gainUp >= FULL_EXT) gainNext = FULL_EXT[GAIN_W-1:0];
        else                    gainNext = gainUp[GAIN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gain <= '0;
    else       gain <= gainNext;
  end

  // muted latches once the down fade has reached zero; releases on unmute
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) muted <= 1'b1;
    else       muted <= muteReq & (muted | (gain == '0));
  end

  assign muteStatusN = rstN & ~powerDown & ~clkRatioErr & ~muted;

  assign ctl.load  = frameStb;
  assign ctl.clear = powerDown;
  assign ctl.gain  = gain;

  // R1: gain never leaves the 0..FULL scale
  p_gain_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    gain <= FULL_EXT[GAIN_W-1:0]);

  // R2: a down step never raises gain and never exceeds the largest step
  p_down_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && !powerDown && muteReq) |=>
      (gain <= $past(gain)) && (($past(gain) - gain) <= GAIN_W'(STEP_SINGLE)));

  // R3: an up step never lowers gain
  p_up_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && !powerDown && !muteReq) |=>
      (gain >= $past(gain)) && ((gain - $past(gain)) <= GAIN_W'(STEP_SINGLE)));

  // R11: without a strobe the gain holds
  p_gain_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStb && !powerDown) |=> $stable(gain));

  // R6: the muted flag only ever stands at zero gain
  p_muted_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    muted |-> (gain == '0));

  // R7: releasing the request clears the flag at the next edge
  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    !muteReq |=> !muted);

  // R10: power-down zeroes gain at the next edge
  p_pdn_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (gain == '0));

endmodule

// File: rtl/mute_ramp_gain_map.sv
module mute_ramp_gain_map
  import mute_ramp_pkg::*;
#(
  parameter int FULL   = FULL_SCALE,
  parameter int FRAC   = FRAC_W,
  parameter int SHIFT  = 16
) (
  input  logic [GAIN_W-1:0] gain,
  output logic [FRAC:0]     gainQ
);

  localparam longint unsigned SCALE =
    ((64'd1 << (FRAC + SHIFT)) + longint'(FULL) - 1) / longint'(FULL);
  localparam int SCALE_W = $clog2(SCALE + 1);
  localparam int WIDE_W  = GAIN_W + SCALE_W;
  localparam logic [WIDE_W-1:0] ONE_WIDE = WIDE_W'(1) << FRAC;

  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] shifted;

  assign wide    = WIDE_W'(gain) * WIDE_W'(SCALE);
  assign shifted = wide >> SHIFT;

  always_comb begin
    if (gain >= GAIN_W'(FULL))  gainQ = ONE_WIDE[FRAC:0];
    else if (shifted > ONE_WIDE) gainQ = ONE_WIDE[FRAC:0];
    else                        gainQ = shifted[FRAC:0];
  end

endmodule

// File: rtl/mute_ramp_scaler.sv
module mute_ramp_scaler
  import mute_ramp_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int FRAC = FRAC_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 load,
  input  logic                 clear,
  input  logic [FRAC:0]        gainQ,
  input  logic signed [DW-1:0] sampleIn,
  output logic signed [DW-1:0] sampleOut
);

  localparam int PROD_W = DW + FRAC + 2;
  localparam logic signed [PROD_W-1:0] MAX_V =
    {{(PROD_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] MIN_V = ~MAX_V;
  localparam logic signed [PROD_W-1:0] HALF_V = PROD_W'(1) <<< (FRAC - 1);
  localparam logic [FRAC:0] ONE_Q = (FRAC+1)'(1) << FRAC;

  logic signed [PROD_W-1:0] sampleExt;
  logic signed [PROD_W-1:0] gainExt;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;
  logic signed [DW-1:0]     satVal;

  assign sampleExt = PROD_W'(sampleIn);
  assign gainExt   = $signed(PROD_W'(gainQ));
  assign prod      = sampleExt * gainExt;
  assign shifted   = (prod + HALF_V) >>> FRAC;

  always_comb begin
    if (shifted > MAX_V)      satVal = MAX_V[DW-1:0];
    else if (shifted < MIN_V) satVal = MIN_V[DW-1:0];
    else                      satVal = shifted[DW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      sampleOut <= '0;
    else if (clear) sampleOut <= '0;
    else if (load)  sampleOut <= satVal;
  end

  // R5: zero gain gives exact silence
  p_zero_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    (load && !clear && gainQ == '0) |=> (sampleOut == '0));

  // R5: unity gain passes the sample bit for bit
  p_unity_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    (load && !clear && gainQ == ONE_Q) |=> (sampleOut == $past(sampleIn)));

  // R11: output holds between strobes
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !clear) |=> $stable(sampleOut));

  // R10: power-down clears the output
  p_out_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (sampleOut == '0));

endmodule

// File: rtl/mute_ramp_datapath.sv
module mute_ramp_datapath
  import mute_ramp_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int FRAC  = FRAC_W,
  parameter int CHANS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         ctl,
  input  logic signed [DW-1:0] chanIn  [CHANS],
  output logic signed [DW-1:0] chanOut [CHANS]
);

  logic [FRAC:0] gainQ;

  mute_ramp_gain_map #(.FULL(FULL_SCALE), .FRAC(FRAC), .SHIFT(16)) uGainMap (
    .gain  (ctl.gain),
    .gainQ (gainQ)
  );

  for (genvar c = 0; c < CHANS; c++) begin : gChan
    mute_ramp_scaler #(.DW(DW), .FRAC(FRAC)) uScaler (
      .clk       (clk),
      .rstN      (rstN),
      .load      (ctl.load),
      .clear     (ctl.clear),
      .gainQ     (gainQ),
      .sampleIn  (chanIn[c]),
      .sampleOut (chanOut[c])
    );
  end

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import mute_ramp_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 powerDown,
  input  logic                 clkRatioErr,
  input  logic [1:0]           rateMode,
  input  logic                 muteReq,
  input  logic                 frameStb,
  input  logic signed [DW-1:0] sampleL,
  input  logic signed [DW-1:0] sampleR,
  output logic signed [DW-1:0] outL,
  output logic signed [DW-1:0] outR,
  output logic                 muteStatusN
);

  localparam int CHANS = 2;

  ctrl_strobe_t         ctl;
  logic signed [DW-1:0] chanIn  [CHANS];
  logic signed [DW-1:0] chanOut [CHANS];

  assign chanIn[0] = sampleL;
  assign chanIn[1] = sampleR;
  assign outL      = chanOut[0];
  assign outR      = chanOut[1];

  mute_ramp_ctrl #(.FULL(FULL_SCALE)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .powerDown   (powerDown),
    .clkRatioErr (clkRatioErr),
    .rateMode    (rateMode),
    .muteReq     (muteReq),
    .frameStb    (frameStb),
    .ctl         (ctl),
    .muteStatusN (muteStatusN)
  );

  mute_ramp_datapath #(.DW(DW), .FRAC(FRAC_W), .CHANS(CHANS)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .chanIn  (chanIn),
    .chanOut (chanOut)
  );

endmodule

// File: tb/tb_soft_mute_ramp.sv
`timescale 1ns/1ps
module tb_soft_mute_ramp;

  localparam int FULL = 4608;
  localparam int NV = 8;
  localparam int VEC_L [NV] = '{8388607, -8388608, 0, -1, 1, 4194304, -123457, 2796202};
  localparam int VEC_R [NV] = '{-8388608, 8388607, -1, 0, 5000000, -4194304, 765432, -2796203};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerDown = 1'b0;
  logic clkRatioErr = 1'b0;
  logic [1:0] rateMode = 2'b00;
  logic muteReq = 1'b0;
  logic frameStb = 1'b0;
  logic signed [23:0] sampleL = '0;
  logic signed [23:0] sampleR = '0;
  logic signed [23:0] outL, outR;
  logic muteStatusN;

  int checks = 0;
  int fails = 0;
  int kGain = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  soft_mute_ramp dut (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .clkRatioErr(clkRatioErr),
    .rateMode(rateMode), .muteReq(muteReq), .frameStb(frameStb),
    .sampleL(sampleL), .sampleR(sampleR), .outL(outL), .outR(outR),
    .muteStatusN(muteStatusN)
  );

  function automatic int stepOf(input logic [1:0] m);
    if (m == 2'b00) return 4;
    if (m == 2'b01) return 2;
    return 1;
  endfunction

  function automatic int expOut(input int s, input int k);
    longint num = longint'(s) * longint'(k);
    if (num >= 0) return int'((num + FULL/2) / FULL);
    return -int'((-num + FULL/2) / FULL);
  endfunction

  task automatic checkInt(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input int act, input int s, input int k);
    int e = expOut(s, k);
    int d = act - e;
    checks++;
    if (k == 0 || k == FULL) begin
      if (act != e) begin
        fails++;
        $display("FAIL %s actual=%0d expected=%0d (gain %0d)", req, act, e, k);
      end
    end else if (d > 2 || d < -2) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d+/-2 (gain %0d)", req, act, e, k);
    end
  endtask

  // one frame: strobe at a falling edge, read outputs at the next falling edge
  task automatic sendFrame(input int sl, input int sr, input string req);
    @(negedge clk);
    sampleL  = 24'(sl);
    sampleR  = 24'(sr);
    frameStb = 1'b1;
    @(negedge clk);
    frameStb = 1'b0;
    checkOut(req, int'(outL), sl, kGain);
    checkOut(req, int'(outR), sr, kGain);
    if (powerDown) kGain = 0;
    else if (muteReq) kGain = (kGain > stepOf(rateMode)) ? kGain - stepOf(rateMode) : 0;
    else kGain = (kGain + stepOf(rateMode) >= FULL) ? FULL : kGain + stepOf(rateMode);
  endtask

  task automatic runFrames(input int n, input string req);
    for (int i = 0; i < n; i++) sendFrame(4194304 - i * 97, -3000000 + i * 53, req);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state (R8, R10)
    repeat (3) @(negedge clk);
    checkInt("R8 status low in reset", int'(muteStatusN), 0);
    checkInt("R10 outL zero after reset", int'(outL), 0);
    checkInt("R10 outR zero after reset", int'(outR), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkInt("R7 status high after reset without mute", int'(muteStatusN), 1);

    // R1/R3/R4/R10: single-rate up fade from zero, 1152 frames to unity
    kGain = 0;
    sendFrame(4194304, -4194304, "R10 first frame silent");
    runFrames(1151, "R3 R4 single up fade");
    checkInt("R1 single fade reaches unity after 1152 frames", kGain, FULL);
    sendFrame(4194304, -4194304, "R1 unity after single fade");

    // vector table at unity (R5)
    for (int i = 0; i < NV; i++) sendFrame(VEC_L[i], VEC_R[i], "R5 unity pass-through");

    // R11: inputs move without a strobe, outputs hold
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      sampleL = 24'(i * 1111 + 7);
      sampleR = 24'(-i * 2222 - 9);
    end
    @(negedge clk);
    checkInt("R11 outL held", int'(outL), VEC_L[NV-1]);
    checkInt("R11 outR held", int'(outR), VEC_R[NV-1]);
    sendFrame(1000, -1000, "R11 gain unchanged without strobes");

    // R2/R6: single-rate down fade
    muteReq = 1'b1;
    for (int i = 0; i < 1151; i++) begin
      sendFrame(2796202, -2796202, "R2 R4 single down fade");
      if (i % 128 == 0) checkInt("R6 status high during down fade", int'(muteStatusN), 1);
    end
    sendFrame(2796202, -2796202, "R2 last down step");
    checkInt("R1 single down fade reaches zero", kGain, 0);
    checkInt("R6 status still high one edge after zeroing frame", int'(muteStatusN), 1);
    @(negedge clk);
    checkInt("R6 status low after fade completes", int'(muteStatusN), 0);
    sendFrame(8388607, -8388608, "R5 zero gain silence");
    checkInt("R6 status stays low while muted", int'(muteStatusN), 0);

    // R7: release, then double-rate up fade
    rateMode = 2'b01;
    @(negedge clk);
    muteReq = 1'b0;
    @(negedge clk);
    checkInt("R7 status high one edge after release", int'(muteStatusN), 1);
    runFrames(2304, "R3 R4 double up fade");
    checkInt("R1 double fade length", kGain, FULL);
    sendFrame(-8388608, 8388607, "R1 unity after double fade");

    // R9: quad-rate reversal mid fade
    rateMode = 2'b10;
    muteReq = 1'b1;
    runFrames(1000, "R2 quad down partial");
    checkInt("R6 status high mid fade", int'(muteStatusN), 1);
    muteReq = 1'b0;
    runFrames(1000, "R9 reversed up fade");
    checkInt("R9 gain back at unity", kGain, FULL);
    sendFrame(VEC_L[0], VEC_R[0], "R9 exact unity after reversal");

    // R1: mode 3 behaves as quad, 4608 frames to zero
    rateMode = 2'b11;
    muteReq = 1'b1;
    runFrames(4607, "R1 R4 quad-b down fade");
    checkInt("R1 status high before final quad step", int'(muteStatusN), 1);
    sendFrame(1234567, -1234567, "R1 final quad step");
    checkInt("R1 quad-b fade reaches zero", kGain, 0);
    @(negedge clk);
    checkInt("R6 status low after quad fade", int'(muteStatusN), 0);

    // R8: clock-ratio error forces status low at once
    muteReq = 1'b0;
    rateMode = 2'b00;
    runFrames(1152, "R3 single up again");
    @(negedge clk);
    clkRatioErr = 1'b1;
    #1;
    checkInt("R8 status low on clock-ratio error", int'(muteStatusN), 0);
    @(negedge clk);
    clkRatioErr = 1'b0;
    #1;
    checkInt("R8 status high after clock-ratio error clears", int'(muteStatusN), 1);

    // R10/R8: power-down clears gain and outputs
    powerDown = 1'b1;
    #1;
    checkInt("R8 status low in power-down", int'(muteStatusN), 0);
    @(negedge clk);
    kGain = 0;
    checkInt("R10 outL cleared by power-down", int'(outL), 0);
    sendFrame(5000000, -5000000, "R10 silent during power-down");
    powerDown = 1'b0;
    runFrames(10, "R10 up fade restarts from zero after power-down");

    // R10: reset with mute held keeps status low
    muteReq = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    kGain = 0;
    repeat (2) @(negedge clk);
    checkInt("R10 status low after reset with mute held", int'(muteStatusN), 0);
    sendFrame(8388607, 8388607, "R10 silent after reset with mute");
    muteReq = 1'b0;
    @(negedge clk);
    checkInt("R7 status high after release post reset", int'(muteStatusN), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule